// File: doc/BRIEF.md
# Packed Decimal Byte Add/Subtract Unit

This block performs one step of multi-byte packed-decimal arithmetic on two bytes, each holding two decimal digits. For addition it computes destination plus source plus the incoming extend bit. For subtraction it computes destination minus source minus the incoming extend bit. It returns the byte result and the five condition flags of a classic 32-bit CISC processor: extend, negative, zero, overflow and carry. It works on the low digit first and then on the high digit, and it applies the decimal corrections in the same order.

A caller chains bytes from least significant to most significant. It feeds the extend and zero flags from each step into the next. The zero flag is sticky, so at the end of the chain it shows whether the whole multi-byte result is zero. The flags match the processor exactly for operand bytes that are not valid decimal, including how the overflow flag is taken from the high-digit correction.

Inputs are sampled when the strobe is high. The result and all flags are registered and appear on the next clock edge, together with a one-cycle completion pulse. Operand fetch and addressing are handled outside this block.

Top module: `bcd_arith_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result`, all five flags and `done` are cleared to 0.
- R2: The low digit is computed as an 8-bit value that wraps: `dst[3:0] + src[3:0] + x_in` for add, or `dst[3:0] - src[3:0] - x_in` for subtract. If that value is 0x0A or more (unsigned), 6 is added to it for add, or subtracted from it for subtract.
- R3: The intermediate byte is `dst[7:4]` placed in bits 7:4, plus the corrected low value, kept to 8 bits. `src[7:4]` placed in bits 7:4 is then added to it (add) or subtracted from it (subtract). The carry or borrow out of this second step is kept.
- R4: `flag_c` is 1 when that carry or borrow occurred, or when the byte after that step is 0xA0 or more (unsigned). When `flag_c` is 1, the final result is that byte plus 0x60 (add) or minus 0x60 (subtract). Otherwise the result is that byte unchanged.
- R5: `flag_v` is the signed two's-complement overflow of the 0x60 correction when the correction is applied, and 0 when it is not.
- R6: `flag_x` always equals `flag_c`.
- R7: `flag_n` equals bit 7 of the final result.
- R8: `flag_z` is 0 when the final result is nonzero, and equals `z_in` when the final result is zero.
- R9: `op_sub` = 0 selects add and `op_sub` = 1 selects subtract.
- R10: The result and flags appear on the rising edge after a cycle in which `in_valid` is high. `done` is high for exactly that one cycle. When `in_valid` is low, the result and flags keep their values and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| src | input | 8 | Source byte |
| dst | input | 8 | Destination byte |
| x_in | input | 1 | Incoming extend flag |
| z_in | input | 1 | Incoming zero flag |
| result | output | 8 | Registered decimal result |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag (sticky) |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry/borrow flag |
| done | output | 1 | One-cycle result pulse |

## Verification
The high-digit decimal correction and the sticky zero rule can act on the same operation. This happens when the 0x60 correction wraps the byte to exactly zero, as in 0x99 + 0x01. In that case carry is set and the zero flag has to follow `z_in` instead of being forced. The bench provokes this in a two-byte chain with `z_in` both set and clear, and it checks result, carry and zero together. The exhaustive operand sweep also changes `x_in` and `z_in` with the operands, so this overlap appears many more times. In every case the outputs are compared against an integer model written from the requirements.

// File: rtl/bcd_arith_pkg.sv
// Package: shared widths and the operation type for the decimal unit.
// Assumes a two-digit packed byte: DIGIT_W of 4 is the only meaningful value.
package bcd_arith_pkg;
    localparam int DIGIT_W  = 4;
    localparam int BYTE_W   = 2 * DIGIT_W;
    localparam logic [BYTE_W-1:0] LOW_MASK  = {{DIGIT_W{1'b0}}, {DIGIT_W{1'b1}}};
    localparam logic [BYTE_W-1:0] HIGH_MASK = {{DIGIT_W{1'b1}}, {DIGIT_W{1'b0}}};
    localparam logic [BYTE_W-1:0] LOW_LIMIT = BYTE_W'(10);
    localparam logic [BYTE_W-1:0] LOW_FIX   = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] HIGH_LIMIT = BYTE_W'(160);
    localparam logic [BYTE_W-1:0] HIGH_FIX   = BYTE_W'(96);

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } bcd_op_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } bcd_flags_t;
endpackage

// File: rtl/bcd_low_digit.sv
// Module: low-digit stage. Combines the low nibbles with the extend bit and
// applies the +/-6 correction when the raw value reaches ten or more.
// Assumes: arithmetic is 8-bit and wraps, so a borrow leaves a large value.
module bcd_low_digit
    import bcd_arith_pkg::*;
(
    input  bcd_op_e             op,
    input  logic [BYTE_W-1:0]   src,
    input  logic [BYTE_W-1:0]   dst,
    input  logic                x_in,
    output logic [BYTE_W-1:0]   low_adj
);
    logic [BYTE_W-1:0] src_lo;
    logic [BYTE_W-1:0] dst_lo;
    logic [BYTE_W-1:0] x_ext;
    logic [BYTE_W-1:0] raw;

    // Isolate the low nibbles and widen the extend bit.
    always_comb begin
        src_lo = src & LOW_MASK;
        dst_lo = dst & LOW_MASK;
        x_ext  = {{(BYTE_W-1){1'b0}}, x_in};
    end

    // Raw low-digit sum or difference, wrapping at 8 bits (R2).
    always_comb begin
        if (op == OP_SUB) raw = dst_lo - src_lo - x_ext;
        else              raw = dst_lo + src_lo + x_ext;
    end

    // Decimal correction by six when the raw value reaches ten.
    always_comb begin
        if (raw >= LOW_LIMIT) begin
            if (op == OP_SUB) low_adj = raw - LOW_FIX;
            else              low_adj = raw + LOW_FIX;
        end else begin
            low_adj = raw;
        end
    end
endmodule

// File: rtl/bcd_high_digit.sv
// Module: high-digit stage. Merges the corrected low value with the high
// nibbles, derives carry, applies the +/-0x60 correction and its overflow.
// Assumes: low_adj comes from bcd_low_digit for the same operands.
module bcd_high_digit
    import bcd_arith_pkg::*;
(
    input  bcd_op_e             op,
    input  logic [BYTE_W-1:0]   src,
    input  logic [BYTE_W-1:0]   dst,
    input  logic [BYTE_W-1:0]   low_adj,
    output logic [BYTE_W-1:0]   res,
    output logic                carry,
    output logic                ovf
);
    logic [BYTE_W-1:0] src_hi;
    logic [BYTE_W-1:0] mid;
    logic [BYTE_W:0]   step;
    logic [BYTE_W-1:0] pre;
    logic              step_out;

    // Intermediate byte: destination high digit plus corrected low value.
    always_comb begin
        src_hi = src & HIGH_MASK;
        mid    = (dst & HIGH_MASK) + low_adj;
    end

    // Final high-digit step with its carry or borrow kept (R3).
    always_comb begin
        if (op == OP_SUB) step = {1'b0, mid} - {1'b0, src_hi};
        else              step = {1'b0, mid} + {1'b0, src_hi};
        pre      = step[BYTE_W-1:0];
        step_out = step[BYTE_W];
    end

    // Carry decision and the 0x60 correction with its signed overflow.
    always_comb begin
        carry = step_out || (pre >= HIGH_LIMIT);
        res   = pre;
        ovf   = 1'b0;
        if (carry) begin
            if (op == OP_SUB) begin
                res = pre - HIGH_FIX;
                ovf = pre[BYTE_W-1] & ~res[BYTE_W-1];
            end else begin
                res = pre + HIGH_FIX;
                ovf = ~pre[BYTE_W-1] & res[BYTE_W-1];
            end
        end
    end

    // R5
    always_comb begin
        if (!carry) begin
            no_corr_no_ovf_chk: assert (ovf == 1'b0);
        end
    end
endmodule

// File: rtl/bcd_arith_unit.sv
// Module: top of the packed-decimal byte unit. Samples operands on in_valid,
// runs the low and high digit stages, and registers result, flags and done.
// Assumes: caller chains x and z between bytes; reset is synchronous, active low.
module bcd_arith_unit
    import bcd_arith_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        op_sub,
    input  logic [7:0]  src,
    input  logic [7:0]  dst,
    input  logic        x_in,
    input  logic        z_in,
    output logic [7:0]  result,
    output logic        flag_x,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c,
    output logic        done
);
    bcd_op_e            op;
    logic [BYTE_W-1:0]  low_adj;
    logic [BYTE_W-1:0]  next_res;
    logic               next_c;
    logic               next_v;
    bcd_flags_t         next_f;
    bcd_flags_t         flags_q;
    logic [BYTE_W-1:0]  res_q;
    logic               done_q;

    // Decode the operation select into the shared type (R9).
    assign op = op_sub ? OP_SUB : OP_ADD;

    bcd_low_digit u_low (
        .op      (op),
        .src     (src),
        .dst     (dst),
        .x_in    (x_in),
        .low_adj (low_adj)
    );

    bcd_high_digit u_high (
        .op      (op),
        .src     (src),
        .dst     (dst),
        .low_adj (low_adj),
        .res     (next_res),
        .carry   (next_c),
        .ovf     (next_v)
    );

    // Assemble next flags; zero is cleared on nonzero and kept otherwise.
    always_comb begin
        next_f.c = next_c;
        next_f.x = next_c;
        next_f.v = next_v;
        next_f.n = next_res[BYTE_W-1];
        next_f.z = (next_res != '0) ? 1'b0 : z_in;
    end

    // Output registers: load on strobe, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= in_valid;
            if (in_valid) begin
                res_q   <= next_res;
                flags_q <= next_f;
            end
        end
    end

    assign result = res_q;
    assign flag_x = flags_q.x;
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
    assign flag_c = flags_q.c;
    assign done   = done_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!done && $stable(result) && $stable(flag_c) && $stable(flag_z)));
    // R8
    zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((result != 8'h00) || (flag_z == $past(z_in))));
    // R8
    zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != 8'h00) |-> !flag_z);
    // R6
    x_follows_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_x == flag_c));
endmodule

// File: tb/bcd_arith_unit_tb_top.sv
module bcd_arith_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       op_sub = 1'b0;
    logic [7:0] src = 8'h00;
    logic [7:0] dst = 8'h00;
    logic       x_in = 1'b0;
    logic       z_in = 1'b0;
    logic [7:0] result;
    logic       flag_x, flag_n, flag_z, flag_v, flag_c, done;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    bcd_arith_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .src(src), .dst(dst), .x_in(x_in), .z_in(z_in),
        .result(result), .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .done(done)
    );

    // Integer model from the requirements: returns {result, x, n, z, v, c}.
    function automatic logic [12:0] model(input logic sub, input int s, input int d,
                                          input int x, input int z);
        int lo, t, f, g, sg;
        logic cy, ov;
        lo = sub ? (d % 16) - (s % 16) - x : (d % 16) + (s % 16) + x;
        lo = lo & 255;
        if (lo >= 10) lo = (sub ? lo - 6 : lo + 6) & 255;
        t  = ((d & 240) + lo) & 255;
        f  = sub ? t - (s & 240) : t + (s & 240);
        cy = (f < 0) || (f > 255);
        f  = f & 255;
        cy = cy || (f >= 160);
        g  = f;
        ov = 1'b0;
        if (cy) begin
            sg = (f >= 128) ? f - 256 : f;
            sg = sub ? sg - 96 : sg + 96;
            ov = (sg > 127) || (sg < -128);
            g  = (sub ? f - 96 : f + 96) & 255;
        end
        return {g[7:0], cy, g[7], (g == 0) ? z[0] : 1'b0, ov, cy};
    endfunction

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got res=%h xnzvc=%b, expected res=%h xnzvc=%b",
                     req, act[12:5], act[4:0], exp[12:5], exp[4:0]);
        end
    endtask

    function automatic logic [12:0] outs();
        return {result, flag_x, flag_n, flag_z, flag_v, flag_c};
    endfunction

    // One operation: drive, then sample one cycle later at the falling edge.
    task automatic run_one(input string req, input logic sub, input logic [7:0] s,
                           input logic [7:0] d, input logic x, input logic z);
        @(negedge clk);
        op_sub = sub; src = s; dst = d; x_in = x; z_in = z; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, outs(), model(sub, int'(s), int'(d), int'(x), int'(z)));
        n_checks++;
        if (done !== 1'b1) begin
            n_errors++;
            $display("FAIL R10: done=%b expected 1", done);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        check("R1", outs(), 13'h0);
        n_checks++;
        if (done !== 1'b0) begin n_errors++; $display("FAIL R1: done=%b expected 0", done); end
        rst_n = 1'b1;
    endtask

    task automatic t_corners();
        // R2 R9: low digit correction in add
        run_one("R2", 1'b0, 8'h05, 8'h05, 1'b0, 1'b1);
        check("R2", outs(), {8'h10, 5'b00000});
        // R4 R5: high wrap via 0x90+0x90 gives 0x80 with overflow
        run_one("R5", 1'b0, 8'h90, 8'h90, 1'b0, 1'b0);
        check("R5", outs(), {8'h80, 5'b11011});
        // R3 R7: borrow 0x00-0x01 gives 0x99
        run_one("R3", 1'b1, 8'h01, 8'h00, 1'b0, 1'b0);
        check("R7", outs(), {8'h99, 5'b11001});
        // R5 subtract overflow: 0xA0-0x00 gives 0x40
        run_one("R5", 1'b1, 8'h00, 8'hA0, 1'b0, 1'b0);
        check("R5", outs(), {8'h40, 5'b10011});
        // R6 extend in subtract with x set: 0x10-0x00-1 = 0x09
        run_one("R6", 1'b1, 8'h00, 8'h10, 1'b1, 1'b1);
        check("R6", outs(), {8'h09, 5'b00000});
    endtask

    task automatic t_sticky_chain();
        // R8: 0x99+0x01 wraps to 00 with carry, zero follows z_in
        run_one("R8", 1'b0, 8'h01, 8'h99, 1'b0, 1'b1);
        check("R8", outs(), {8'h00, 5'b10101});
        run_one("R8", 1'b0, 8'h00, 8'h99, 1'b1, 1'b1);
        check("R8", outs(), {8'h00, 5'b10101});
        run_one("R8", 1'b0, 8'h01, 8'h99, 1'b0, 1'b0);
        check("R8", outs(), {8'h00, 5'b10001});
        run_one("R8", 1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
        check("R8", outs(), {8'h00, 5'b00100});
        run_one("R8", 1'b0, 8'h01, 8'h00, 1'b0, 1'b1);
        check("R8", outs(), {8'h01, 5'b00000});
    endtask

    task automatic t_hold_idle();
        logic [12:0] snap;
        run_one("R10", 1'b0, 8'h45, 8'h37, 1'b1, 1'b0);
        snap = outs();
        @(negedge clk);
        op_sub = 1'b1; src = 8'h12; dst = 8'h34; x_in = 1'b1; z_in = 1'b1;
        repeat (3) @(negedge clk);
        // R10: inputs changing without strobe leave outputs alone
        check("R10", outs(), snap);
        n_checks++;
        if (done !== 1'b0) begin n_errors++; $display("FAIL R10: done=%b expected 0", done); end
    endtask

    // Exhaustive operand sweep for one operation, one vector per cycle.
    task automatic t_sweep(input logic sub);
        logic [12:0] exp_prev;
        exp_prev = '0;
        for (int i = 0; i < 65536; i++) begin
            logic [7:0] s, d;
            logic x, z;
            s = i[7:0]; d = i[15:8];
            x = s[0] ^ d[1]; z = s[1] ^ d[0] ^ s[4];
            @(negedge clk);
            if (i > 0) check(sub ? "R9 sub sweep" : "R4 add sweep", outs(), exp_prev);
            op_sub = sub; src = s; dst = d; x_in = x; z_in = z; in_valid = 1'b1;
            exp_prev = model(sub, int'(s), int'(d), int'(x), int'(z));
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(sub ? "R9 sub sweep" : "R4 add sweep", outs(), exp_prev);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_corners();
        t_sticky_chain();
        t_hold_idle();
        t_sweep(1'b0);
        t_sweep(1'b1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule